// File: doc/BRIEF.md
# RDS block synchronizer with data-available flag

This block sits after the RDS block decoder and takes one report per block period. Each report is a one-cycle strobe with a block type, a flag for a block with no errors and a flag for a block that was repaired by correction. While not synchronized, the block looks at good and bad blocks to decide when the block stream is locked. It declares lock when one error-free block is followed by another, with at most a programmable number of bad blocks between them.

Once locked, every block that can be used (error-free or corrected) can raise a data-available flag toward the host. An active-low interrupt follows that flag. A half-rate mode raises the flag only on every second usable block. The host clears the flag with a read strobe. The payload of each usable A block is shifted into a two-deep history, which holds the newest and the previous A block.

Top module: `rds_sync_flag`

## Requirements
- R1: During the search, only a block with type code 0..4 (A=0, B=1, C=2, C'=3, D=4) and `blk_ok` high counts as good. A block that is only corrected (`blk_fixed`), or a block with type code 5..7, counts as bad.
- R2: Lock is declared (`sync_o` high one cycle after the strobe) when a good block arrives after an earlier good block, with no more than `bad_tol` bad blocks between them.
- R3: If the run of bad blocks after a good block grows past `bad_tol`, the search is cleared and no lock results. The next good block starts a new search.
- R4: Once high, `sync_o` stays high until reset.
- R5: In full-rate mode (`half_rate` low), each usable block received while locked sets `flag_o` one cycle after its strobe. A usable block has type code 0..4 and `blk_ok` or `blk_fixed` high. This holds for A and C' blocks even when no valid B block came before them. The block that completes the search does not set the flag.
- R6: In half-rate mode, a pair toggle advances on each usable locked block, and only every second such block sets `flag_o`. The toggle starts cleared after reset and does not advance in full-rate mode.
- R7: `host_rd` clears `flag_o` on the next cycle. When a read and a flag set fall in the same cycle, the flag ends up set.
- R8: `int_n` is low exactly when `flag_o` is high.
- R9: A usable A block received while locked moves `a_last` into `a_prev` and loads `blk_data` into `a_last`. Other block types leave both unchanged.
- R10: A synchronous reset clears `sync_o`, `flag_o`, the search state, the pair toggle and both history registers, and sets `int_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| blk_stb | input | 1 | One-cycle strobe marking a decoded block report |
| blk_type | input | 3 | Block type code (A=0, B=1, C=2, C'=3, D=4) |
| blk_ok | input | 1 | Block decoded with no errors |
| blk_fixed | input | 1 | Block repaired by error correction |
| blk_data | input | DW | Block payload |
| half_rate | input | 1 | Raise the flag on every second usable block |
| bad_tol | input | TOLW | Longest allowed run of bad blocks during the search |
| host_rd | input | 1 | Host read strobe, clears the flag |
| sync_o | output | 1 | Lock status |
| flag_o | output | 1 | Data available |
| int_n | output | 1 | Interrupt, active low |
| a_last | output | DW | Newest accepted A block |
| a_prev | output | DW | A block accepted before `a_last` |

## Verification
The assertions check properties that must hold on every cycle. Lock never drops, and no flag is seen before lock. The interrupt mirrors the flag. A read with no strobe in the same cycle clears the flag. A rising flag or a rising lock must follow a strobe, and a lock must follow an error-free one. The history must shift as a pair. Only the bench scenarios can show whether the bad-run counting agrees with `bad_tol` at each tolerance setting, how corrected blocks and unknown type codes are sorted during the search, and the pairing in half-rate mode. The bench also covers a read that lands on the same cycle as a set.

// File: rtl/rds_sync_flag.sv
module rds_sync_flag #(
  parameter int DW   = 16,
  parameter int TOLW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            blk_stb,
  input  logic [2:0]      blk_type,
  input  logic            blk_ok,
  input  logic            blk_fixed,
  input  logic [DW-1:0]   blk_data,
  input  logic            half_rate,
  input  logic [TOLW-1:0] bad_tol,
  input  logic            host_rd,
  output logic            sync_o,
  output logic            flag_o,
  output logic            int_n,
  output logic [DW-1:0]   a_last,
  output logic [DW-1:0]   a_prev
);
  localparam logic [2:0] TYP_A   = 3'd0;
  localparam logic [2:0] TYP_MAX = 3'd4;

  logic            have_good;
  logic [TOLW-1:0] bad_run;
  logic            pend;

  wire type_ok = blk_type <= TYP_MAX;
  wire good    = blk_stb & type_ok & blk_ok;
  wire bad     = blk_stb & ~good;
  wire accept  = blk_stb & sync_o & type_ok & (blk_ok | blk_fixed);
  wire set_now = accept & (~half_rate | pend);

  assign int_n = ~flag_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_good <= 1'b0;
      bad_run   <= '0;
      sync_o    <= 1'b0;
    end else if (!sync_o) begin
      if (good) begin
        if (have_good) sync_o <= 1'b1;
        have_good <= 1'b1;
        bad_run   <= '0;
      end else if (bad && have_good) begin
        if (bad_run >= bad_tol) begin
          have_good <= 1'b0;
          bad_run   <= '0;
        end else begin
          bad_run <= bad_run + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend   <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      if (accept && half_rate) pend <= ~pend;
      if (set_now)      flag_o <= 1'b1;
      else if (host_rd) flag_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_last <= '0;
      a_prev <= '0;
    end else if (accept && blk_type == TYP_A) begin
      a_prev <= a_last;
      a_last <= blk_data;
    end
  end

  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (rst)
    sync_o |=> sync_o); // R4
  AST_SYNC_FROM_GOOD: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $past(blk_stb && blk_ok && blk_type <= TYP_MAX)); // R2
  AST_NO_FLAG_UNSYNC: assert property (@(posedge clk) disable iff (rst)
    !sync_o |-> !flag_o); // R5
  AST_FLAG_FROM_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(blk_stb)); // R5
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (host_rd && !blk_stb) |=> !flag_o); // R7
  AST_INT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    int_n != flag_o); // R8
  AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (a_last != $past(a_last)) |-> (a_prev == $past(a_last))); // R9
endmodule

// File: tb/tb_rds_sync_flag.sv
module tb_rds_sync_flag;
  localparam int DW  = 16;
  localparam int GAP = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blk_stb = 0, blk_ok = 0, blk_fixed = 0, half_rate = 0, host_rd = 0;
  logic [2:0] blk_type = 0;
  logic [DW-1:0] blk_data = 0;
  logic [1:0] bad_tol = 2;
  logic sync_o, flag_o, int_n;
  logic [DW-1:0] a_last, a_prev;

  rds_sync_flag #(.DW(DW), .TOLW(2)) dut (
    .clk(clk), .rst(rst), .blk_stb(blk_stb), .blk_type(blk_type),
    .blk_ok(blk_ok), .blk_fixed(blk_fixed), .blk_data(blk_data),
    .half_rate(half_rate), .bad_tol(bad_tol), .host_rd(host_rd),
    .sync_o(sync_o), .flag_o(flag_o), .int_n(int_n),
    .a_last(a_last), .a_prev(a_prev));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;

  task automatic check(string tag, longint got, longint exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  // reference model
  int m_sync, m_flag, m_seen, m_run, m_pair;
  int hist[$];

  always @(posedge clk) begin
    if (rst) begin
      m_sync = 0; m_flag = 0; m_seen = 0; m_run = 0; m_pair = 0;
      hist = {0, 0};
    end else begin
      bit known, use_it, is_good, setf;
      known   = blk_type <= 4;
      is_good = blk_stb && known && blk_ok;
      use_it  = blk_stb && m_sync == 1 && known && (blk_ok || blk_fixed);
      setf = 0;
      if (use_it) begin
        if (!half_rate) setf = 1;
        else begin
          if (m_pair == 1) setf = 1;
          m_pair = 1 - m_pair;
        end
        if (blk_type == 0) begin
          hist.push_front(int'(blk_data));
          void'(hist.pop_back());
        end
      end
      if (setf) m_flag = 1;
      else if (host_rd) m_flag = 0;
      if (m_sync == 0 && blk_stb) begin
        if (is_good) begin
          if (m_seen == 1) m_sync = 1;
          m_seen = 1; m_run = 0;
        end else if (m_seen == 1) begin
          m_run++;
          if (m_run > int'(bad_tol)) begin m_seen = 0; m_run = 0; end
        end
      end
    end
  end

  always @(negedge clk) if (!rst) begin
    check("R2 R3 R4 sync_o", sync_o, m_sync);
    check("R5 R6 R7 flag_o", flag_o, m_flag);
    check("R8 int_n", int_n, !m_flag);
    check("R9 a_last", a_last, hist[0]);
    check("R9 a_prev", a_prev, hist[1]);
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int t, bit ok, bit fx, int d, bit rd = 0);
    @(negedge clk);
    blk_stb = 1; blk_type = 3'(t); blk_ok = ok; blk_fixed = fx;
    blk_data = DW'(d); host_rd = rd;
    @(negedge clk);
    blk_stb = 0; blk_ok = 0; blk_fixed = 0; host_rd = 0;
    idle(GAP);
  endtask

  task automatic rd_pulse();
    @(negedge clk); host_rd = 1;
    @(negedge clk); host_rd = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk); rst = 0;
  endtask

  initial begin
    #2_000_000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10 reset state
    check("R10 sync", sync_o, 0); check("R10 flag", flag_o, 0);
    check("R10 int_n", int_n, 1); check("R10 hist", {a_last, a_prev}, 0);
    // R2: good, bad, bad, good at tolerance 2
    send(0, 1, 0, 16'h1111); send(1, 0, 0, 0); send(2, 0, 0, 0);
    check("R2 no lock yet", sync_o, 0);
    send(3, 1, 0, 0);
    check("R2 lock", sync_o, 1); check("R5 no flag on locking block", flag_o, 0);
    // R5 full rate, R9 history
    send(0, 0, 1, 16'hA001);
    check("R5 flag", flag_o, 1); check("R9 last", a_last, 16'hA001);
    rd_pulse(); check("R7 cleared", flag_o, 0);
    send(3, 1, 0, 0); check("R5 C' sets without B", flag_o, 1);
    rd_pulse();
    send(0, 1, 0, 16'hA002);
    check("R9 prev", a_prev, 16'hA001); check("R9 last2", a_last, 16'hA002);
    send(1, 1, 0, 16'hBBBB, 1); check("R7 set wins", flag_o, 1);
    check("R9 B leaves history", a_last, 16'hA002);
    send(6, 1, 0, 0); send(0, 0, 0, 16'hDEAD);
    check("R9 bad A ignored", a_last, 16'hA002);
    rd_pulse();
    // R6 half rate
    half_rate = 1;
    send(1, 1, 0, 0); check("R6 first of pair", flag_o, 0);
    send(2, 1, 0, 0); check("R6 second of pair", flag_o, 1);
    rd_pulse();
    send(0, 1, 0, 16'hA003); check("R6 odd", flag_o, 0);
    send(3, 0, 1, 0); check("R6 even", flag_o, 1);
    rd_pulse(); half_rate = 0;
    // R3: three bad exceed tolerance 2
    do_reset();
    send(0, 1, 0, 0); send(1, 0, 0, 0); send(2, 0, 0, 0); send(3, 0, 0, 0);
    send(4, 1, 0, 0); check("R3 no lock after overrun", sync_o, 0);
    send(0, 1, 0, 0); check("R3 restart locks", sync_o, 1);
    // R1: corrected counts bad at tolerance 0
    do_reset(); bad_tol = 0;
    send(0, 1, 0, 0); send(1, 0, 1, 0); send(2, 1, 0, 0);
    check("R1 fixed is bad", sync_o, 0);
    send(7, 1, 0, 0); send(3, 1, 0, 0);
    check("R1 code 7 is bad", sync_o, 0);
    send(4, 1, 0, 0); check("R1 two good lock", sync_o, 1);
    // R4 persistence
    send(6, 0, 0, 0); send(5, 0, 0, 0); send(1, 0, 0, 0); send(2, 0, 0, 0);
    check("R4 stays locked", sync_o, 1);
    // tolerance 3
    do_reset(); bad_tol = 3;
    send(0, 1, 0, 0); repeat (3) send(2, 0, 1, 0); send(1, 1, 0, 0);
    check("R2 lock at tol 3", sync_o, 1);
    idle(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule